// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Bank

This block stores the per-window settings of a display controller that composes two overlay windows. Every setting has two copies. Software writes into a staging copy, and the scan-out logic reads a live copy. The live copy changes only on a rising edge of the frame sync input, so a frame never starts with half of a new configuration.

Software arms a transfer by writing the update-request register. On the next rising frame sync edge, each armed window that is not frozen copies its staging values into the live set. A window is frozen by setting its bit in the hold register. A frozen window keeps its transfer pending until it is released. This lets software change several registers of one window without any risk that a frame edge picks up a partial set.

Each window has a control word (enable and format), an inclusive top-left corner, an inclusive bottom-right corner and a buffer base address. Only window 1 also has a colour-key word. Register reads always return the staging value. A status bit reports whether any window still has a transfer waiting.

Top module: `winshadow_bank`

## Requirements
- R1: After reset, every staging and live value is zero, no window is held and no transfer is outstanding.
- R2: A write to a window register changes its staging copy. Readback returns the written value masked to the field layout, and the live outputs do not change until a transfer. Window w occupies word addresses 8w..8w+4: control, top-left, bottom-right, base, key. Unused addresses read 0.
- R3: Writing a word with bit 0 set to address 17 arms every window. Writing a word with bit 0 clear has no effect. Bit 0 of address 17 and `upd_pending` read 1 while any window is still armed.
- R4: On the clock edge where `vsync` is high after having been low, every armed window that is not held copies all of its staging values to its live outputs and disarms. The new values are visible after that edge.
- R5: A rising `vsync` edge while no window is armed leaves every live output unchanged.
- R6: Bit w of address 16 holds window w. A held window is skipped at the frame edge and stays armed. At the first rising edge after its hold bit is cleared, it takes its latest staging values.
- R7: Setting or clearing the window enable (control bit 0) reaches `act_en` only through a frame-edge transfer.
- R8: Window 0 has no key register. Writes to address 4 are ignored, address 4 reads 0, and the live key of window 0 is 0. The key of window 1 (address 12) is a full data word.
- R9: Both corners are inclusive positions with x in bits 11:0 and y in bits 27:16 of the word. All other bits are dropped. On the live outputs each corner is packed as {y, x}.
- R10: A request written in the same cycle as a rising `vsync` edge leaves every window armed after that edge.
- R11: A `vsync` level held high for several cycles counts as a single edge. A window armed while the level stays high waits for the next low-to-high change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame sync level, sampled on clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | DW | Staging value at rd_addr (combinational) |
| upd_pending | output | 1 | Some window still waits for a transfer |
| act_en | output | NWIN | Live enable per window |
| act_fmt | output | NWIN*FW | Live format code per window |
| act_origin | output | NWIN*2*CW | Live inclusive top-left {y,x} per window |
| act_corner | output | NWIN*2*CW | Live inclusive bottom-right {y,x} per window |
| act_base | output | NWIN*DW | Live buffer base per window |
| act_key | output | NWIN*DW | Live colour key per window (window 0 is zero) |

## Verification
Directed sequences separate the cases that an always-copy design would merge: a frame edge with nothing armed, an edge with one window held and the other free, release of a hold, a request that lands on the edge itself, and a sync level held high across a request. A random phase then mixes writes to every address (including out-of-range bits, the key slot of window 0, hold bits and requests) with random sync toggling. Against a bench model of staging, live, armed and held state, this random phase tells apart designs that use the wrong edge, the wrong hold sample or a copy of a value that was written in the same cycle.

// File: rtl/winshadow_pkg.sv
package winshadow_pkg;
  localparam int unsigned WIN_STRIDE = 8;
  localparam int unsigned Y_LSB      = 16;

  typedef enum logic [2:0] {
    FLD_CTRL   = 3'd0,
    FLD_ORIGIN = 3'd1,
    FLD_CORNER = 3'd2,
    FLD_BASE   = 3'd3,
    FLD_KEY    = 3'd4
  } field_e;

  function automatic int unsigned hold_addr(input int unsigned nwin);
    return nwin * WIN_STRIDE;
  endfunction

  function automatic int unsigned req_addr(input int unsigned nwin);
    return nwin * WIN_STRIDE + 1;
  endfunction
endpackage

// File: rtl/winshadow_edge.sv
module winshadow_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  output logic vs_rise
);
  logic vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync;
  end

  assign vs_rise = vsync & ~vs_q;

  // R11: a held level yields one edge only
  p_single_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> !vs_rise);
endmodule

// File: rtl/winshadow_arm.sv
module winshadow_arm #(
  parameter int unsigned NWIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vs_rise,
  input  logic            hold_we,
  input  logic [NWIN-1:0] hold_d,
  input  logic            req,
  output logic [NWIN-1:0] hold,
  output logic [NWIN-1:0] armed,
  output logic [NWIN-1:0] copy_en,
  output logic            upd_pending
);
  assign copy_en     = {NWIN{vs_rise}} & armed & ~hold;
  assign upd_pending = |armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      armed <= '0;
    end else begin
      armed <= (armed & ~copy_en) | {NWIN{req}};
      if (hold_we) hold <= hold_d;
    end
  end

  p_req_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> upd_pending);

  p_held_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> ((armed & $past(armed & hold)) == $past(armed & hold)));

  p_free_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !req) |=> ((armed & $past(armed & ~hold)) == '0));

  p_edge_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && req) |=> (&armed));
endmodule

// File: rtl/winshadow_keyreg.sv
module winshadow_keyreg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          copy_en,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] pend,
  output logic [DW-1:0] act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      if (copy_en) act <= pend;
      if (we)      pend <= d;
    end
  end

  p_key_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (act == $past(pend)));
endmodule

// File: rtl/winshadow_window.sv
module winshadow_window #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 12,
  parameter int unsigned FW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            copy_en,
  input  logic            we_ctrl,
  input  logic            we_origin,
  input  logic            we_corner,
  input  logic            we_base,
  input  logic [FW:0]     d_ctrl,
  input  logic [2*CW-1:0] d_xy,
  input  logic [DW-1:0]   d_base,
  output logic [FW:0]     pend_ctrl,
  output logic [2*CW-1:0] pend_origin,
  output logic [2*CW-1:0] pend_corner,
  output logic [DW-1:0]   pend_base,
  output logic [FW:0]     act_ctrl,
  output logic [2*CW-1:0] act_origin,
  output logic [2*CW-1:0] act_corner,
  output logic [DW-1:0]   act_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ctrl   <= '0;
      pend_origin <= '0;
      pend_corner <= '0;
      pend_base   <= '0;
      act_ctrl    <= '0;
      act_origin  <= '0;
      act_corner  <= '0;
      act_base    <= '0;
    end else begin
      if (copy_en) begin
        act_ctrl   <= pend_ctrl;
        act_origin <= pend_origin;
        act_corner <= pend_corner;
        act_base   <= pend_base;
      end
      if (we_ctrl)   pend_ctrl   <= d_ctrl;
      if (we_origin) pend_origin <= d_xy;
      if (we_corner) pend_corner <= d_xy;
      if (we_base)   pend_base   <= d_base;
    end
  end

  p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_en |=> ($stable(act_ctrl) && $stable(act_origin) &&
                  $stable(act_corner) && $stable(act_base)));

  p_copy_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> ((act_ctrl == $past(pend_ctrl)) &&
                 (act_origin == $past(pend_origin)) &&
                 (act_corner == $past(pend_corner)) &&
                 (act_base == $past(pend_base))));
endmodule

// File: rtl/winshadow_bank.sv
module winshadow_bank #(
  parameter int unsigned NWIN = 2,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 12,
  parameter int unsigned FW   = 4,
  parameter int unsigned AW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 upd_pending,
  output logic [NWIN-1:0]      act_en,
  output logic [NWIN*FW-1:0]   act_fmt,
  output logic [NWIN*2*CW-1:0] act_origin,
  output logic [NWIN*2*CW-1:0] act_corner,
  output logic [NWIN*DW-1:0]   act_base,
  output logic [NWIN*DW-1:0]   act_key
);
  import winshadow_pkg::*;

  localparam int unsigned WINW      = AW - 3;
  localparam int unsigned XYW       = 2 * CW;
  localparam int unsigned HOLD_ADDR = hold_addr(NWIN);
  localparam int unsigned REQ_ADDR  = req_addr(NWIN);

  function automatic logic [XYW-1:0] word_to_xy(input logic [DW-1:0] w);
    return {w[Y_LSB +: CW], w[0 +: CW]};
  endfunction

  function automatic logic [DW-1:0] xy_to_word(input logic [XYW-1:0] xy);
    logic [DW-1:0] w;
    w = '0;
    w[0 +: CW]     = xy[CW-1:0];
    w[Y_LSB +: CW] = xy[XYW-1:CW];
    return w;
  endfunction

  logic            vs_rise;
  logic [NWIN-1:0] hold, armed, copy_en;
  logic            hold_we, upd_req;
  logic [WINW-1:0] wr_win, rd_win;
  logic [2:0]      wr_fld, rd_fld;
  logic [XYW-1:0]  d_xy;

  logic [FW:0]     pend_ctrl_a   [NWIN];
  logic [XYW-1:0]  pend_origin_a [NWIN];
  logic [XYW-1:0]  pend_corner_a [NWIN];
  logic [DW-1:0]   pend_base_a   [NWIN];
  logic [DW-1:0]   pend_key_a    [NWIN];
  logic [FW:0]     act_ctrl_a    [NWIN];
  logic [XYW-1:0]  act_origin_a  [NWIN];
  logic [XYW-1:0]  act_corner_a  [NWIN];
  logic [DW-1:0]   act_base_a    [NWIN];
  logic [DW-1:0]   act_key_a     [NWIN];

  assign wr_win  = wr_addr[AW-1:3];
  assign wr_fld  = wr_addr[2:0];
  assign rd_win  = rd_addr[AW-1:3];
  assign rd_fld  = rd_addr[2:0];
  assign d_xy    = word_to_xy(wr_data);
  assign hold_we = wr_en && (wr_addr == AW'(HOLD_ADDR));
  assign upd_req = wr_en && (wr_addr == AW'(REQ_ADDR)) && wr_data[0];

  winshadow_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .vs_rise (vs_rise)
  );

  winshadow_arm #(.NWIN(NWIN)) u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .vs_rise     (vs_rise),
    .hold_we     (hold_we),
    .hold_d      (wr_data[NWIN-1:0]),
    .req         (upd_req),
    .hold        (hold),
    .armed       (armed),
    .copy_en     (copy_en),
    .upd_pending (upd_pending)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel;
    assign sel = wr_en && (wr_win == WINW'(w));

    winshadow_window #(.DW(DW), .CW(CW), .FW(FW)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .copy_en     (copy_en[w]),
      .we_ctrl     (sel && (wr_fld == FLD_CTRL)),
      .we_origin   (sel && (wr_fld == FLD_ORIGIN)),
      .we_corner   (sel && (wr_fld == FLD_CORNER)),
      .we_base     (sel && (wr_fld == FLD_BASE)),
      .d_ctrl      (wr_data[FW:0]),
      .d_xy        (d_xy),
      .d_base      (wr_data),
      .pend_ctrl   (pend_ctrl_a[w]),
      .pend_origin (pend_origin_a[w]),
      .pend_corner (pend_corner_a[w]),
      .pend_base   (pend_base_a[w]),
      .act_ctrl    (act_ctrl_a[w]),
      .act_origin  (act_origin_a[w]),
      .act_corner  (act_corner_a[w]),
      .act_base    (act_base_a[w])
    );

    if (w != 0) begin : g_key
      winshadow_keyreg #(.DW(DW)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .copy_en (copy_en[w]),
        .we      (sel && (wr_fld == FLD_KEY)),
        .d       (wr_data),
        .pend    (pend_key_a[w]),
        .act     (act_key_a[w])
      );
    end else begin : g_nokey
      assign pend_key_a[w] = '0;
      assign act_key_a[w]  = '0;
    end

    assign act_en[w]                = act_ctrl_a[w][0];
    assign act_fmt[w*FW +: FW]      = act_ctrl_a[w][FW:1];
    assign act_origin[w*XYW +: XYW] = act_origin_a[w];
    assign act_corner[w*XYW +: XYW] = act_corner_a[w];
    assign act_base[w*DW +: DW]     = act_base_a[w];
    assign act_key[w*DW +: DW]      = act_key_a[w];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(HOLD_ADDR)) begin
      rd_data[NWIN-1:0] = hold;
    end else if (rd_addr == AW'(REQ_ADDR)) begin
      rd_data[0] = upd_pending;
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (rd_win == WINW'(w)) begin
          case (rd_fld)
            FLD_CTRL:   rd_data = DW'(pend_ctrl_a[w]);
            FLD_ORIGIN: rd_data = xy_to_word(pend_origin_a[w]);
            FLD_CORNER: rd_data = xy_to_word(pend_corner_a[w]);
            FLD_BASE:   rd_data = pend_base_a[w];
            FLD_KEY:    rd_data = pend_key_a[w];
            default:    rd_data = '0;
          endcase
        end
      end
    end
  end

  // R7: enable moves only with a transfer
  p_enable_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|copy_en) |=> $stable(act_en));

  // R5: an edge with nothing armed changes nothing live
  p_idle_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !upd_pending) |=> ($stable(act_base) && $stable(act_en) &&
                                   $stable(act_origin) && $stable(act_key)));
endmodule

// File: tb/test_winshadow_bank.sv
module test_winshadow_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        upd_pending;
  logic [1:0]  act_en;
  logic [7:0]  act_fmt;
  logic [47:0] act_origin, act_corner;
  logic [63:0] act_base, act_key;

  winshadow_bank i_winshadow_bank (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .upd_pending(upd_pending), .act_en(act_en),
    .act_fmt(act_fmt), .act_origin(act_origin), .act_corner(act_corner),
    .act_base(act_base), .act_key(act_key)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] pimg [0:17];
  logic [31:0] aimg [0:1][0:4];
  logic [1:0]  m_armed = '0;
  logic [1:0]  m_hold = '0;
  logic        m_vsp = 1'b0;
  logic        vs_lvl = 1'b0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int a);
    if (a == 16) return 32'h3;
    if (a > 16) return 32'h0;
    case (a % 8)
      0:       return 32'h0000_001F;
      1, 2:    return 32'h0FFF_0FFF;
      3:       return 32'hFFFF_FFFF;
      4:       return (a / 8 == 1) ? 32'hFFFF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 17) return {31'b0, |m_armed};
    if (a == 16) return {30'b0, m_hold};
    if (a > 17) return 32'h0;
    return pimg[a];
  endfunction

  function automatic logic [23:0] xy(input logic [31:0] w);
    return {w[27:16], w[11:0]};
  endfunction

  task automatic model_edge(input logic vs, input logic we, input int a, input logic [31:0] d);
    logic rise;
    logic [1:0] cp;
    rise = vs & ~m_vsp;
    for (int w = 0; w < 2; w++) begin
      cp[w] = rise & m_armed[w] & ~m_hold[w];
      if (cp[w]) for (int f = 0; f < 5; f++) aimg[w][f] = pimg[w*8+f];
    end
    m_armed = m_armed & ~cp;
    if (we) begin
      if (a == 17) begin
        if (d[0]) m_armed = 2'b11;
      end else if (a == 16) m_hold = d[1:0];
      else if (a < 16) pimg[a] = d & wmask(a);
    end
    m_vsp = vs;
  endtask

  task automatic check_live(input string tag);
    for (int w = 0; w < 2; w++) begin
      chk(tag, 64'(act_en[w]), 64'(aimg[w][0][0]));
      chk(tag, 64'(act_fmt[w*4 +: 4]), 64'(aimg[w][0][4:1]));
      chk(tag, 64'(act_origin[w*24 +: 24]), 64'(xy(aimg[w][1])));
      chk(tag, 64'(act_corner[w*24 +: 24]), 64'(xy(aimg[w][2])));
      chk(tag, 64'(act_base[w*32 +: 32]), 64'(aimg[w][3]));
      chk(tag, 64'(act_key[w*32 +: 32]), 64'(aimg[w][4]));
    end
    chk(tag, 64'(upd_pending), 64'(|m_armed));
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic vs, input logic we, input int a, input logic [31:0] d,
                     input string tag);
    vs_lvl  = vs;
    vsync   = vs;
    wr_en   = we;
    wr_addr = 5'(a);
    wr_data = d;
    @(posedge clk);
    model_edge(vs, we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_live(tag);
    rd_addr = 5'($urandom % 18);
    #1;
    chk({tag, "/read"}, 64'(rd_data), 64'(exp_rd(int'(rd_addr))));
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    cyc(vs_lvl, 1'b1, a, d, tag);
  endtask

  task automatic idle(input string tag);
    cyc(vs_lvl, 1'b0, 0, 32'h0, tag);
  endtask

  task automatic vpulse(input string tag);
    cyc(1'b1, 1'b0, 0, 32'h0, tag);
    cyc(1'b0, 1'b0, 0, 32'h0, tag);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    rd_addr = 5'(a);
    #1;
    chk(tag, 64'(rd_data), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 18; a++) pimg[a] = '0;
    for (int w = 0; w < 2; w++) for (int f = 0; f < 5; f++) aimg[w][f] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_live("R1");
    for (int a = 0; a < 18; a++) rd_chk(a, 32'h0, "R1");

    // R3: request with bit 0 clear does nothing
    wr(17, 32'hFFFF_FFFE, "R3");
    chk("R3", 64'(upd_pending), 64'd0);

    // R2: staging only
    wr(0, 32'hFFFF_FFE5, "R2");
    wr(3, 32'hABCD_0000, "R2");
    rd_chk(0, 32'h0000_0005, "R2");
    rd_chk(3, 32'hABCD_0000, "R2");
    chk("R7", 64'(act_en[0]), 64'd0);

    // R5: edge with nothing armed
    vpulse("R5");
    chk("R5", 64'(act_base[31:0]), 64'd0);

    // R3 + R4: arm and transfer
    wr(17, 32'h1, "R3");
    chk("R3", 64'(upd_pending), 64'd1);
    rd_chk(17, 32'h1, "R3");
    vpulse("R4");
    chk("R4", 64'(act_base[31:0]), 64'hABCD_0000);
    chk("R7", 64'(act_en[0]), 64'd1);
    chk("R4", 64'(act_fmt[3:0]), 64'd2);
    chk("R4", 64'(upd_pending), 64'd0);

    // R6: hold window 1
    wr(16, 32'h2, "R6");
    wr(8, 32'h1, "R6");
    wr(11, 32'h1234_5678, "R6");
    wr(12, 32'hDEAD_BEEF, "R6");
    wr(17, 32'h1, "R6");
    vpulse("R6");
    chk("R6", 64'(act_en[1]), 64'd0);
    chk("R6", 64'(upd_pending), 64'd1);
    wr(16, 32'h0, "R6");
    vpulse("R6");
    chk("R6", 64'(act_en[1]), 64'd1);
    chk("R6", 64'(act_base[63:32]), 64'h1234_5678);
    chk("R8", 64'(act_key[63:32]), 64'hDEAD_BEEF);
    chk("R6", 64'(upd_pending), 64'd0);

    // R8: window 0 key slot ignored
    wr(4, 32'hFFFF_FFFF, "R8");
    rd_chk(4, 32'h0, "R8");
    wr(17, 32'h1, "R8");
    vpulse("R8");
    chk("R8", 64'(act_key[31:0]), 64'd0);

    // R9: inclusive corner fields
    wr(1, 32'hFFFF_FFFF, "R9");
    rd_chk(1, 32'h0FFF_0FFF, "R9");
    wr(2, 32'h0123_0456, "R9");
    wr(17, 32'h1, "R9");
    vpulse("R9");
    chk("R9", 64'(act_origin[23:0]), 64'hFFF_FFF);
    chk("R9", 64'(act_corner[23:0]), 64'h123_456);

    // R7: disable waits for the edge
    wr(0, 32'h0, "R7");
    wr(17, 32'h1, "R7");
    idle("R7");
    chk("R7", 64'(act_en[0]), 64'd1);
    vpulse("R7");
    chk("R7", 64'(act_en[0]), 64'd0);

    // R10: request on the edge cycle
    wr(17, 32'h1, "R10");
    cyc(1'b1, 1'b1, 17, 32'h1, "R10");
    chk("R10", 64'(upd_pending), 64'd1);
    cyc(1'b0, 1'b0, 0, 32'h0, "R10");
    vpulse("R10");
    chk("R10", 64'(upd_pending), 64'd0);

    // R11: held level is one edge
    cyc(1'b1, 1'b0, 0, 32'h0, "R11");
    wr(3, 32'h5555_AAAA, "R11");
    wr(17, 32'h1, "R11");
    idle("R11");
    idle("R11");
    chk("R11", 64'(act_base[31:0]), 64'hABCD_0000);
    chk("R11", 64'(upd_pending), 64'd1);
    cyc(1'b0, 1'b0, 0, 32'h0, "R11");
    cyc(1'b1, 1'b0, 0, 32'h0, "R11");
    chk("R11", 64'(act_base[31:0]), 64'h5555_AAAA);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic we;
      int a;
      logic [31:0] d;
      if ($urandom % 6 == 0) vs_lvl = ~vs_lvl;
      we = 1'($urandom % 2);
      a = int'($urandom % 18);
      d = $urandom;
      cyc(vs_lvl, we, a, d, "R4");
    end

    for (int a = 0; a < 18; a++) rd_chk(a, exp_rd(a), "R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule